// File: doc/BRIEF.md
# Bit-Serial Query-Key Pruning Lane

This block is one lane of an attention engine that scores a group of key tokens against a single query vector, one key bit-plane at a time. The sign plane comes first and the least significant plane comes last. For each accepted plane the lane ANDs the plane with the query and adds up the selected query elements. It folds that sum into the token's running score in its scoreboard. It then works out the smallest and largest final score the token can still reach. A token whose best case falls below a running threshold is dropped at once. The fetcher sees the drop on the live mask and stops sending planes for that token.

The threshold is the largest lower bound seen since the query was loaded, less a margin. A smaller margin drops more tokens. Tokens that get through all twelve planes leave the lane with their exact score. The same partial sums serve both for pruning and as the final result, so no separate estimate pass is needed. Planes for different tokens can arrive in any interleaving.

Top module: `qk_prune_lane`

## Requirements
- R1: After reset, planeReady, survValid and done are low and tokLive is all zero.
- R2: A qLoad pulse stores the sixteen signed 8-bit query elements (element i in qVec bits 8i+7..8i), the margin and the token count n (1..64). One cycle later tokLive has bits 0..n-1 set and planeReady is high.
- R3: Key elements are 12-bit two's complement. Round 0 carries bit 11 (weight -2048) and round k carries bit 11-k. planeBits bit i is key element i's bit, and a survivor's score equals the exact signed dot product of the query and the token's key.
- R4: After a token's plane of round k is applied, with r = 11-k planes left, its upper bound is acc*2^r + P*(2^r-1) and its lower bound is acc*2^r + N*(2^r-1). P is the sum of the positive query elements and N is the sum of the negative ones. The token is pruned when the upper bound is below the threshold.
- R5: The threshold is the largest lower bound produced since the last qLoad, including the current plane's own, minus the margin. It never falls during a query, and a new qLoad clears it.
- R6: A pruned token's tokLive bit clears one cycle after its plane is accepted. It is never emitted, and later planes for it have no effect.
- R7: While planeReady is high every valid plane is accepted. A plane is discarded with no effect on state or outputs when its token index is not below n, the token is not live, or planeRound is not that token's next round.
- R8: A token whose round-11 plane is applied and is not pruned gives a one-cycle survValid pulse one cycle after acceptance, with survTok and survScore. Its tokLive bit clears at the same time.
- R9: done pulses for one cycle, together with the last token's outcome, once all n tokens are pruned or emitted. planeReady is low from that cycle on until the next qLoad.
- R10: Each token keeps its own round count, so planes of different tokens may arrive interleaved in any order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| qLoad | input | 1 | Load query, margin and token count, and start a new group |
| qVec | input | 128 | Sixteen signed 8-bit query elements |
| qTokens | input | 7 | Number of tokens in the group (1..64) |
| pruneMargin | input | 25 | Unsigned margin subtracted from the best lower bound |
| planeValid | input | 1 | Key bit-plane present |
| planeReady | output | 1 | Lane accepts planes (a query is active) |
| planeBits | input | 16 | One key bit per query element |
| planeTok | input | 6 | Token index of the plane |
| planeRound | input | 4 | Round number of the plane, 0 = sign plane |
| tokLive | output | 64 | Tokens still waiting for planes |
| survValid | output | 1 | Survivor output valid (one-cycle pulse) |
| survTok | output | 6 | Survivor token index |
| survScore | output | 25 | Survivor exact signed score |
| done | output | 1 | All tokens of the group resolved (one-cycle pulse) |

## Verification
Every accepted plane has one registered outcome, and it is due exactly one clock after the accepting edge. That outcome is the tokLive update, the survivor pulse with its score, or the done pulse. The bench drives each plane half a cycle before an edge and reads all of these at the following falling edge, before the next plane goes in, so each check ties to one plane. tokLive and planeReady after a qLoad are read one cycle after the load. The bench checks scores against a direct dot product and predicts pruning from bounds it computes itself.

// File: rtl/qk_lane_pkg.sv
package qk_lane_pkg;
  parameter int NUM_TOK  = 64;
  parameter int KEY_BITS = 12;
  parameter int Q_LEN    = 16;
  parameter int Q_BITS   = 8;
  localparam int TOK_W = $clog2(NUM_TOK);
  localparam int CNT_W = TOK_W + 1;
  localparam int RND_W = $clog2(KEY_BITS);
  localparam int SUM_W = Q_BITS + $clog2(Q_LEN) + 1;
  localparam int ACC_W = SUM_W + KEY_BITS;
  localparam int CMP_W = ACC_W + 2;

  typedef struct packed {
    logic             loadQ;
    logic             step;
    logic [TOK_W-1:0] tok;
    logic [RND_W-1:0] rnd;
  } ctrlStrb_t;
endpackage

// File: rtl/qk_lane_dp.sv
module qk_lane_dp
  import qk_lane_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  ctrlStrb_t                strb,
  input  logic [Q_LEN*Q_BITS-1:0]  qVec,
  input  logic [ACC_W-1:0]         pruneMargin,
  input  logic [Q_LEN-1:0]         planeBits,
  output logic                     pruneNow,
  output logic signed [ACC_W-1:0]  scoreOut
);
  logic signed [Q_BITS-1:0] qMem [Q_LEN];
  logic signed [ACC_W-1:0]  sb [NUM_TOK];
  logic signed [SUM_W-1:0]  posSum, negSum, posIn, negIn, planeSum;
  logic signed [CMP_W-1:0]  best, bestCand, thr, upper, lower, tail, accExt;
  logic signed [ACC_W-1:0]  newAcc;
  logic                     bestValid;
  logic [ACC_W-1:0]         marginQ;
  logic [RND_W-1:0]         remain;

  always_comb begin
    posIn = '0;
    negIn = '0;
    for (int i = 0; i < Q_LEN; i++) begin
      if (qVec[i*Q_BITS + Q_BITS-1]) negIn += SUM_W'($signed(qVec[i*Q_BITS +: Q_BITS]));
      else                           posIn += SUM_W'($signed(qVec[i*Q_BITS +: Q_BITS]));
    end
  end

  always_comb begin
    planeSum = '0;
    for (int i = 0; i < Q_LEN; i++)
      if (planeBits[i]) planeSum += SUM_W'(qMem[i]);
    if (strb.rnd == '0) newAcc = -ACC_W'(planeSum);
    else                newAcc = (sb[strb.tok] <<< 1) + ACC_W'(planeSum);
    remain   = RND_W'(KEY_BITS-1) - strb.rnd;
    tail     = (CMP_W'(1) <<< remain) - CMP_W'(1);
    accExt   = CMP_W'(newAcc) <<< remain;
    upper    = accExt + CMP_W'(posSum) * tail;
    lower    = accExt + CMP_W'(negSum) * tail;
    bestCand = (bestValid && best > lower) ? best : lower;
    thr      = bestCand - $signed({2'b00, marginQ});
    pruneNow = upper < thr;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      posSum    <= '0;
      negSum    <= '0;
      best      <= '0;
      bestValid <= 1'b0;
      marginQ   <= '0;
      scoreOut  <= '0;
      for (int i = 0; i < Q_LEN; i++) qMem[i] <= '0;
    end else if (strb.loadQ) begin
      posSum    <= posIn;
      negSum    <= negIn;
      bestValid <= 1'b0;
      marginQ   <= pruneMargin;
      for (int i = 0; i < Q_LEN; i++) qMem[i] <= $signed(qVec[i*Q_BITS +: Q_BITS]);
    end else if (strb.step) begin
      best      <= bestCand;
      bestValid <= 1'b1;
      scoreOut  <= newAcc;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.step && !strb.loadQ) sb[strb.tok] <= newAcc;
  end
endmodule

// File: rtl/qk_lane_ctrl.sv
module qk_lane_ctrl
  import qk_lane_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              qLoad,
  input  logic [CNT_W-1:0]  qTokens,
  input  logic              planeValid,
  input  logic [TOK_W-1:0]  planeTok,
  input  logic [RND_W-1:0]  planeRound,
  input  logic              pruneNow,
  output ctrlStrb_t         strb,
  output logic              planeReady,
  output logic [NUM_TOK-1:0] tokLive,
  output logic              survValid,
  output logic [TOK_W-1:0]  survTok,
  output logic              done
);
  logic [RND_W-1:0] rndArr [NUM_TOK];
  logic [CNT_W-1:0] tokCount, resolved;
  logic             active, apply, last, resolveNow;

  assign planeReady = active;
  assign apply = active && !qLoad && planeValid && ({1'b0, planeTok} < tokCount)
                 && tokLive[planeTok] && (planeRound == rndArr[planeTok]);
  assign last       = rndArr[planeTok] == RND_W'(KEY_BITS-1);
  assign resolveNow = apply && (last || pruneNow);

  always_comb begin
    strb.loadQ = qLoad;
    strb.step  = apply;
    strb.tok   = planeTok;
    strb.rnd   = rndArr[planeTok];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active    <= 1'b0;
      tokLive   <= '0;
      tokCount  <= '0;
      resolved  <= '0;
      survValid <= 1'b0;
      survTok   <= '0;
      done      <= 1'b0;
      for (int t = 0; t < NUM_TOK; t++) rndArr[t] <= '0;
    end else if (qLoad) begin
      active    <= 1'b1;
      tokCount  <= qTokens;
      resolved  <= '0;
      survValid <= 1'b0;
      done      <= 1'b0;
      for (int t = 0; t < NUM_TOK; t++) begin
        rndArr[t]  <= '0;
        tokLive[t] <= (CNT_W'(t) < qTokens);
      end
    end else begin
      survValid <= apply && last && !pruneNow;
      survTok   <= planeTok;
      done      <= resolveNow && (resolved + 1'b1 == tokCount);
      if (apply) rndArr[planeTok] <= rndArr[planeTok] + 1'b1;
      if (resolveNow) begin
        tokLive[planeTok] <= 1'b0;
        resolved <= resolved + 1'b1;
        if (resolved + 1'b1 == tokCount) active <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/qk_prune_lane.sv
module qk_prune_lane
  import qk_lane_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     qLoad,
  input  logic [Q_LEN*Q_BITS-1:0]  qVec,
  input  logic [CNT_W-1:0]         qTokens,
  input  logic [ACC_W-1:0]         pruneMargin,
  input  logic                     planeValid,
  output logic                     planeReady,
  input  logic [Q_LEN-1:0]         planeBits,
  input  logic [TOK_W-1:0]         planeTok,
  input  logic [RND_W-1:0]         planeRound,
  output logic [NUM_TOK-1:0]       tokLive,
  output logic                     survValid,
  output logic [TOK_W-1:0]         survTok,
  output logic signed [ACC_W-1:0]  survScore,
  output logic                     done
);
  ctrlStrb_t strb;
  logic      pruneNow;

  qk_lane_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .qLoad(qLoad), .qTokens(qTokens),
    .planeValid(planeValid), .planeTok(planeTok), .planeRound(planeRound),
    .pruneNow(pruneNow), .strb(strb), .planeReady(planeReady),
    .tokLive(tokLive), .survValid(survValid), .survTok(survTok), .done(done)
  );

  qk_lane_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .qVec(qVec),
    .pruneMargin(pruneMargin), .planeBits(planeBits),
    .pruneNow(pruneNow), .scoreOut(survScore)
  );
endmodule

// File: rtl/qk_prune_lane_chk.sv
module qk_prune_lane_chk
  import qk_lane_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               qLoad,
  input logic               planeReady,
  input logic [NUM_TOK-1:0] tokLive,
  input logic               survValid,
  input logic [TOK_W-1:0]   survTok,
  input logic               done
);
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  a_r9_ready_low_at_done: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !planeReady);
  a_r8_emitted_not_live: assert property (@(posedge clk) disable iff (!rstN)
    survValid |-> !tokLive[survTok]);
  a_r6_live_never_rises: assert property (@(posedge clk) disable iff (!rstN)
    !qLoad |=> ((tokLive & ~$past(tokLive)) == '0));
  a_r8_surv_single: assert property (@(posedge clk) disable iff (!rstN)
    (survValid && !qLoad) |=> !survValid || $changed(survTok));
endmodule

bind qk_prune_lane qk_prune_lane_chk u_chk (
  .clk(clk), .rstN(rstN), .qLoad(qLoad), .planeReady(planeReady),
  .tokLive(tokLive), .survValid(survValid), .survTok(survTok), .done(done)
);

// File: tb/qk_prune_lane_bench.sv
module qk_prune_lane_bench;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         qLoad = 1'b0;
  logic [127:0] qVec = '0;
  logic [6:0]   qTokens = '0;
  logic [24:0]  pruneMargin = '0;
  logic         planeValid = 1'b0;
  logic         planeReady;
  logic [15:0]  planeBits = '0;
  logic [5:0]   planeTok = '0;
  logic [3:0]   planeRound = '0;
  logic [63:0]  tokLive;
  logic         survValid;
  logic [5:0]   survTok;
  logic [24:0]  survScore;
  logic         done;

  int checks = 0, errors = 0;
  int qv [16];
  int keyMem [64][16];
  longint mAcc [64];
  int mRnd [64];
  bit mLive [64];
  longint mBest, mMargin, mP, mN;
  bit mBestValid;
  int mCount, mResolved;
  int seed = 12345;

  always #10 clk = ~clk;

  qk_prune_lane u_qk_prune_lane (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int nextRand(input int range);
    seed = seed * 1103515245 + 12345;
    return ((seed >>> 8) & 32'h7fffff) % range;
  endfunction

  task automatic loadQuery(input int n, input longint margin);
    @(negedge clk);
    mP = 0; mN = 0;
    for (int i = 0; i < 16; i++) begin
      qVec[i*8 +: 8] = 8'(qv[i]);
      if (qv[i] > 0) mP += qv[i]; else mN += qv[i];
    end
    qTokens = 7'(n); pruneMargin = 25'(margin); qLoad = 1'b1;
    @(negedge clk);
    qLoad = 1'b0;
    mBestValid = 0; mMargin = margin; mCount = n; mResolved = 0;
    for (int t = 0; t < 64; t++) begin mAcc[t] = 0; mRnd[t] = 0; mLive[t] = (t < n); end
    chk(planeReady == 1'b1, "R2 ready", planeReady, 1);
    chk(tokLive == ((n == 64) ? '1 : ((64'd1 << n) - 1)), "R2 live mask", tokLive, (64'd1 << n) - 1);
  endtask

  function automatic longint dotOf(input int t);
    longint s = 0;
    for (int i = 0; i < 16; i++) s += longint'(qv[i]) * keyMem[t][i];
    return s;
  endfunction

  // Send one plane: tok, round tag, and the key bit-plane taken from round bitRnd.
  task automatic sendPlane(input int t, input int rTag, input int bitRnd);
    bit apply, prune, emit, last;
    longint s, lo, up, thr, cand, tail;
    int r;
    for (int i = 0; i < 16; i++) planeBits[i] = keyMem[t][i][11-bitRnd];
    planeTok = 6'(t); planeRound = 4'(rTag); planeValid = 1'b1;
    apply = (t < mCount) && mLive[t] && (rTag == mRnd[t]);
    prune = 0; emit = 0; last = 0;
    if (apply) begin
      s = 0;
      for (int i = 0; i < 16; i++) if (planeBits[i]) s += qv[i];
      mAcc[t] = (mRnd[t] == 0) ? -s : 2 * mAcc[t] + s;
      r = 11 - mRnd[t];
      tail = (longint'(1) << r) - 1;
      up = mAcc[t] * (longint'(1) << r) + mP * tail;
      lo = mAcc[t] * (longint'(1) << r) + mN * tail;
      cand = (mBestValid && mBest > lo) ? mBest : lo;
      mBest = cand; mBestValid = 1;
      thr = cand - mMargin;
      prune = up < thr;
      last = (mRnd[t] == 11);
      emit = last && !prune;
      mRnd[t]++;
      if (prune || last) begin mLive[t] = 0; mResolved++; end
    end
    @(posedge clk);
    @(negedge clk);
    planeValid = 1'b0;
    chk(survValid == emit, apply ? "R8 survivor pulse" : "R7 ignored plane no output", survValid, emit);
    if (emit) begin
      chk(survTok == 6'(t), "R8 survivor index", survTok, t);
      chk($signed(survScore) == dotOf(t), "R3 exact score", $signed(survScore), dotOf(t));
    end
    chk(tokLive[t] == mLive[t], prune ? "R4 prune bound" : "R6 live bit", tokLive[t], mLive[t]);
    chk(done == (apply && (prune || last) && mResolved == mCount), "R9 done pulse", done, mResolved == mCount);
    if (done) chk(planeReady == 1'b0, "R9 ready low", planeReady, 0);
  endtask

  task automatic randKeys(input int n, input int span);
    for (int t = 0; t < n; t++)
      for (int i = 0; i < 16; i++) keyMem[t][i] = nextRand(2 * span) - span;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(planeReady == 0 && survValid == 0 && done == 0 && tokLive == 0, "R1 reset state", {planeReady, survValid, done}, 0);
    rstN = 1'b1;
    @(negedge clk);

    // S1: no pruning (huge margin), round-major order; R3 covers sign plane incl. -2048
    for (int i = 0; i < 16; i++) qv[i] = nextRand(256) - 128;
    qv[0] = -128; qv[1] = 127;
    randKeys(6, 2048);
    keyMem[0][0] = -2048; keyMem[0][1] = 2047; keyMem[1][0] = -1;
    loadQuery(6, 25'h1ffffff);
    for (int r = 0; r < 12; r++)
      for (int t = 0; t < 6; t++) sendPlane(t, r, r);

    // S2: aggressive pruning, one dominant token, planes to pruned tokens later (R6, R5)
    for (int i = 0; i < 16; i++) qv[i] = 20 + i;
    for (int i = 0; i < 16; i++) begin keyMem[0][i] = 2047; keyMem[1][i] = -2000; keyMem[2][i] = -1500; keyMem[3][i] = 100; end
    loadQuery(4, 0);
    for (int r = 0; r < 12; r++)
      for (int t = 0; t < 4; t++)
        if (planeReady) sendPlane(t, (mLive[t] || t == 0) ? mRnd[t] : r, r);
    chk(planeReady == 0, "R9 ready after group", planeReady, 0);

    // S3: token-major order (R10), moderate margin, mismatched tags and out-of-range index (R7)
    for (int rep = 0; rep < 4; rep++) begin
      for (int i = 0; i < 16; i++) qv[i] = nextRand(256) - 128;
      randKeys(5, 2048);
      loadQuery(5, 40000 * rep);
      sendPlane(0, 5, 5);
      sendPlane(7, 0, 0);
      for (int t = 4; t >= 0; t--)
        for (int r = 0; r < 12; r++)
          if (mLive[t]) sendPlane(t, r, r);
    end

    // S4: reload mid-group clears threshold and state (R5, R2)
    for (int i = 0; i < 16; i++) qv[i] = nextRand(256) - 128;
    randKeys(3, 512);
    loadQuery(3, 0);
    sendPlane(0, 0, 0);
    sendPlane(1, 0, 0);
    loadQuery(3, 25'h1ffffff);
    for (int r = 0; r < 12; r++)
      for (int t = 0; t < 3; t++) sendPlane(t, r, r);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule